// File: doc/BRIEF.md
# Masked-Write Pin Configuration Bank

This block is the configuration store for one group of 32 general-purpose pins. For each pin it holds four settings: a 4-bit function select, an 8-bit drive-strength field, a 2-bit pull-bias code and a 1-bit input Schmitt-trigger enable. A simple memory-mapped bus writes and reads these settings one 32-bit word at a time. The stored fields are also decoded continuously into flat per-pin vectors that feed the pad logic.

Every register holds 16 data bits. A write carries its own bit-enable mask in the upper half-word, so software can change one field in a single bus cycle without reading the register first. Drive strength is kept as a thermometer code. The block reports each pin's drive level as the number of ones in that code, and it raises a per-pin flag when the field is not a valid thermometer pattern.

The settings for pins 0 to 15 and for pins 16 to 31 sit in two separate address windows. The drive-strength words form a third, contiguous window. The bus gives a word address; any address outside the three windows is inert.

Top module: `pcfg_bank`

## Requirements
- R1: A write updates data bit n (n from 0 to 15) of the addressed register only when bit n+16 of `wdata` is 1. Every data bit whose enable bit is 0 keeps its old value, and a write with an all-zero enable half-word changes nothing.
- R2: When `rst_n` is low, every stored field clears to 0, and so do `rdata` and `rvalid`. This gives function 0, pull code 0, drive field 0 (level 0, no error flag) and Schmitt off on every pin.
- R3: A read accepted with `rd_en` at a clock edge gives `rvalid` = 1 and `rdata` = {16'h0000, stored word} after that edge. If `rd_en` was low, `rvalid` and `rdata` are 0 after the edge. A read and a write to the same address at the same edge return the value from before the write.
- R4: Function select, 4 bits per pin. Word 0x00+k holds pins 4k to 4k+3 for k = 0..3, and word 0x20+k holds pins 16+4k to 19+4k. Pin p sits at bits (p mod 4)*4+3 down to (p mod 4)*4 and drives `pin_func[4p+3:4p]`.
- R5: Drive strength, 8 bits per pin. Word 0x10+floor(p/2) holds pin p at bits (p mod 2)*8+7 down to (p mod 2)*8, and that field drives `pin_drive[8p+7:8p]`.
- R6: Pull bias, 2 bits per pin. Words 0x04 and 0x05 hold pins 0–7 and 8–15, and words 0x24 and 0x25 hold pins 16–23 and 24–31. Pin p sits at bits (p mod 8)*2+1 down to (p mod 8)*2 and drives `pin_pull[2p+1:2p]`.
- R7: Schmitt enable, 1 bit per pin. Words 0x06 and 0x07 hold pins 0–7 and 8–15, and words 0x26 and 0x27 hold pins 16–23 and 24–31. Pin p is at bit (p mod 8) and drives `pin_smt[p]`. Bits 15:8 of these words are not stored and always read as 0.
- R8: `pin_drv_lvl[4p+3:4p]` equals the number of ones in pin p's drive field. `pin_drv_err[p]` is 1 exactly when the field is not of the form 2^k−1 (k = 0..8). Writing level s as (2^(s+1))−1 gives a count of s+1 with no error flag.
- R9: A write to an unmapped address (0x08–0x0F or 0x28–0x3F) changes no output. A read from one gives `rvalid` = 1 with `rdata` = 0.
- R10: A write accepted at a clock edge is visible on the per-pin outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted in the cycle it is high |
| rd_en | input | 1 | Read strobe; data returns one cycle later |
| addr | input | 6 | Word address within the bank |
| wdata | input | 32 | Bits 31:16 are the bit enables, bits 15:0 the data |
| rdata | output | 32 | Read data, upper half always 0 |
| rvalid | output | 1 | High for one cycle when `rdata` carries a read result |
| pin_func | output | 128 | Function select, 4 bits per pin |
| pin_drive | output | 256 | Raw drive-strength thermometer field, 8 bits per pin |
| pin_drv_lvl | output | 128 | Count of ones in each drive field, 4 bits per pin |
| pin_drv_err | output | 32 | Per-pin flag for a drive field that is not a thermometer code |
| pin_pull | output | 64 | Pull-bias code, 2 bits per pin |
| pin_smt | output | 32 | Schmitt-trigger enable, 1 bit per pin |

## Verification
The masked write is tried with a full enable mask, a mask of one nibble or one byte, and an all-zero mask. These separate a correct bit-wise merge from a plain overwrite and from a write that ignores the mask. Writes go to the first and last word of each window and to both the low and high pin regions, and the values are then read back on the per-pin vectors. This catches a wrong field offset, a region mix-up or a swapped pin order, which a bus read-back alone would not show. Drive fields are written with valid thermometer codes of several lengths and with a gapped pattern, so the level count and the error flag are checked separately. Unmapped addresses, the unstored upper half of the Schmitt words, and a read issued in the same cycle as a write show whether the decode and the read timing are right.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int NPINS   = 32;
    localparam int DATA_W  = 16;
    localparam int BUS_W   = 2 * DATA_W;
    localparam int ADDR_W  = 6;

    localparam int FUNC_W  = 4;
    localparam int DRV_W   = 8;
    localparam int PULL_W  = 2;
    localparam int SMT_W   = 1;

    localparam int FUNC_PER_WORD = DATA_W / FUNC_W;
    localparam int DRV_PER_WORD  = DATA_W / DRV_W;
    localparam int PULL_PER_WORD = DATA_W / PULL_W;
    localparam int SMT_PER_WORD  = 8;

    localparam int FUNC_WORDS = NPINS / FUNC_PER_WORD;
    localparam int DRV_WORDS  = NPINS / DRV_PER_WORD;
    localparam int PULL_WORDS = NPINS / PULL_PER_WORD;
    localparam int SMT_WORDS  = NPINS / SMT_PER_WORD;

    localparam int FUNC_BASE = 0;
    localparam int DRV_BASE  = FUNC_BASE + FUNC_WORDS;
    localparam int PULL_BASE = DRV_BASE + DRV_WORDS;
    localparam int SMT_BASE  = PULL_BASE + PULL_WORDS;
    localparam int NWORDS    = SMT_BASE + SMT_WORDS;
    localparam int SLOT_W    = $clog2(NWORDS);

    localparam int LVL_W = $clog2(DRV_W + 1);

    typedef enum logic [2:0] {
        FK_NONE,
        FK_FUNC,
        FK_DRIVE,
        FK_PULL,
        FK_SMT
    } field_kind_e;

    typedef struct packed {
        field_kind_e         kind;
        logic [SLOT_W-1:0]   slot;
        logic [DATA_W-1:0]   mask;
    } slot_sel_t;

endpackage

// File: rtl/pcfg_decode.sv
// Word address -> storage slot and implemented-bit mask.
module pcfg_decode
    import pcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output slot_sel_t         sel
);

    localparam logic [DATA_W-1:0] FULL_MASK = '1;
    localparam logic [DATA_W-1:0] SMT_MASK  = DATA_W'((1 << SMT_PER_WORD) - 1);

    always_comb begin
        sel.kind = FK_NONE;
        sel.slot = '0;
        sel.mask = '0;
        if (addr[5:4] == 2'b01) begin
            // drive window: one contiguous run of words
            sel.kind = FK_DRIVE;
            sel.slot = SLOT_W'(DRV_BASE) + SLOT_W'(addr[3:0]);
            sel.mask = FULL_MASK;
        end else if (addr[4:3] == 2'b00) begin
            // addr[5] picks the low or high pin region
            unique case (addr[2:1])
                2'b00, 2'b01: begin
                    sel.kind = FK_FUNC;
                    sel.slot = SLOT_W'(FUNC_BASE) + SLOT_W'({addr[5], addr[1:0]});
                    sel.mask = FULL_MASK;
                end
                2'b10: begin
                    sel.kind = FK_PULL;
                    sel.slot = SLOT_W'(PULL_BASE) + SLOT_W'({addr[5], addr[0]});
                    sel.mask = FULL_MASK;
                end
                2'b11: begin
                    sel.kind = FK_SMT;
                    sel.slot = SLOT_W'(SMT_BASE) + SLOT_W'({addr[5], addr[0]});
                    sel.mask = SMT_MASK;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcfg_regfile.sv
// Masked-write storage with a registered read port.
module pcfg_regfile
    import pcfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  slot_sel_t                sel,
    input  logic [BUS_W-1:0]         wdata,
    output logic [BUS_W-1:0]         rdata,
    output logic                     rvalid,
    output logic [NWORDS*DATA_W-1:0] cfg_flat
);

    logic [DATA_W-1:0] mem [NWORDS];
    logic [DATA_W-1:0] bit_en;
    logic              hit;

    assign bit_en = wdata[BUS_W-1:DATA_W] & sel.mask;
    assign hit    = (sel.kind != FK_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && hit) begin
            mem[sel.slot] <= (mem[sel.slot] & ~bit_en) | (wdata[DATA_W-1:0] & bit_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? {{DATA_W{1'b0}}, mem[sel.slot] & sel.mask} : '0;
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_flat
        assign cfg_flat[w*DATA_W +: DATA_W] = mem[w];
    end

endmodule

// File: rtl/pcfg_fanout.sv
// Stored words -> flat per-pin vectors, with thermometer level and check.
module pcfg_fanout
    import pcfg_pkg::*;
(
    input  logic [NWORDS*DATA_W-1:0] cfg_flat,
    output logic [NPINS*FUNC_W-1:0]  pin_func,
    output logic [NPINS*DRV_W-1:0]   pin_drive,
    output logic [NPINS*LVL_W-1:0]   pin_drv_lvl,
    output logic [NPINS-1:0]         pin_drv_err,
    output logic [NPINS*PULL_W-1:0]  pin_pull,
    output logic [NPINS*SMT_W-1:0]   pin_smt
);

    function automatic logic [LVL_W-1:0] ones_in(input logic [DRV_W-1:0] f);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int b = 0; b < DRV_W; b++) begin
            n = n + LVL_W'(f[b]);
        end
        return n;
    endfunction

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int FWORD = FUNC_BASE + p / FUNC_PER_WORD;
        localparam int FBIT  = (p % FUNC_PER_WORD) * FUNC_W;
        localparam int DWORD = DRV_BASE + p / DRV_PER_WORD;
        localparam int DBIT  = (p % DRV_PER_WORD) * DRV_W;
        localparam int PWORD = PULL_BASE + p / PULL_PER_WORD;
        localparam int PBIT  = (p % PULL_PER_WORD) * PULL_W;
        localparam int SWORD = SMT_BASE + p / SMT_PER_WORD;
        localparam int SBIT  = (p % SMT_PER_WORD) * SMT_W;

        logic [DRV_W-1:0] dfield;

        assign dfield = cfg_flat[DWORD*DATA_W + DBIT +: DRV_W];

        assign pin_func[p*FUNC_W +: FUNC_W]   = cfg_flat[FWORD*DATA_W + FBIT +: FUNC_W];
        assign pin_drive[p*DRV_W +: DRV_W]    = dfield;
        assign pin_drv_lvl[p*LVL_W +: LVL_W]  = ones_in(dfield);
        assign pin_drv_err[p]                 = |(dfield & (dfield + DRV_W'(1)));
        assign pin_pull[p*PULL_W +: PULL_W]   = cfg_flat[PWORD*DATA_W + PBIT +: PULL_W];
        assign pin_smt[p*SMT_W +: SMT_W]      = cfg_flat[SWORD*DATA_W + SBIT +: SMT_W];
    end

    // Schmitt words keep only their low byte; the rest never reaches a pin.
    localparam int SPARE_W = DATA_W - SMT_PER_WORD * SMT_W;
    logic [SMT_WORDS*SPARE_W-1:0] unused_smt_hi;
    for (genvar s = 0; s < SMT_WORDS; s++) begin : g_spare
        assign unused_smt_hi[s*SPARE_W +: SPARE_W] =
            cfg_flat[(SMT_BASE+s)*DATA_W + SMT_PER_WORD*SMT_W +: SPARE_W];
    end

endmodule

// File: rtl/pcfg_bank.sv
module pcfg_bank
    import pcfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BUS_W-1:0]         wdata,
    output logic [BUS_W-1:0]         rdata,
    output logic                     rvalid,
    output logic [NPINS*FUNC_W-1:0]  pin_func,
    output logic [NPINS*DRV_W-1:0]   pin_drive,
    output logic [NPINS*LVL_W-1:0]   pin_drv_lvl,
    output logic [NPINS-1:0]         pin_drv_err,
    output logic [NPINS*PULL_W-1:0]  pin_pull,
    output logic [NPINS*SMT_W-1:0]   pin_smt
);

    slot_sel_t                sel;
    logic [NWORDS*DATA_W-1:0] cfg_flat;

    pcfg_decode u_decode (
        .addr (addr),
        .sel  (sel)
    );

    pcfg_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sel      (sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .cfg_flat (cfg_flat)
    );

    pcfg_fanout u_fanout (
        .cfg_flat    (cfg_flat),
        .pin_func    (pin_func),
        .pin_drive   (pin_drive),
        .pin_drv_lvl (pin_drv_lvl),
        .pin_drv_err (pin_drv_err),
        .pin_pull    (pin_pull),
        .pin_smt     (pin_smt)
    );

endmodule

// File: rtl/pcfg_bank_chk.sv
module pcfg_bank_chk
    import pcfg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wr_mask,
    input logic [BUS_W-1:0]         rdata,
    input logic                     rvalid,
    input logic [NPINS*FUNC_W-1:0]  pin_func,
    input logic [NPINS*DRV_W-1:0]   pin_drive,
    input logic [NPINS*LVL_W-1:0]   pin_drv_lvl,
    input logic [NPINS-1:0]         pin_drv_err,
    input logic [NPINS*PULL_W-1:0]  pin_pull,
    input logic [NPINS*SMT_W-1:0]   pin_smt
);

    logic mapped;
    logic smt_word;
    assign mapped   = (addr inside {[6'h00:6'h07], [6'h10:6'h1F], [6'h20:6'h27]});
    assign smt_word = (addr inside {6'h06, 6'h07, 6'h26, 6'h27});

    // R3: read data arrives one cycle after the strobe
    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid)
        else $error("a_r3_read_latency");

    // R3: no strobe, no data
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid && rdata == '0))
        else $error("a_r3_idle_quiet");

    // R3: upper half of read data is zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rdata[BUS_W-1:DATA_W] == '0)
        else $error("a_r3_upper_zero");

    // R9: unmapped read returns zero
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> rdata == '0)
        else $error("a_r9_unmapped_read");

    // R9: unmapped write leaves every pin output alone
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(pin_func) && $stable(pin_drive) &&
                                $stable(pin_pull) && $stable(pin_smt)))
        else $error("a_r9_unmapped_write");

    // R1: all-zero enable half-word changes nothing
    a_r1_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0) |=> ($stable(pin_func) && $stable(pin_drive) &&
                                      $stable(pin_pull) && $stable(pin_smt)))
        else $error("a_r1_zero_mask");

    // R10: outputs move only after an accepted write
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_func) && $stable(pin_drive) &&
                    $stable(pin_pull) && $stable(pin_smt)))
        else $error("a_r10_hold_idle");

    // R7: Schmitt words never return data above bit 7
    a_r7_smt_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && smt_word) |=> rdata[DATA_W-1:SMT_PER_WORD] == '0)
        else $error("a_r7_smt_upper");

    // R8: a field without the error flag is the thermometer of its level
    for (genvar p = 0; p < NPINS; p++) begin : g_thermo
        a_r8_thermo_lvl: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_drv_err[p] |->
                pin_drive[p*DRV_W +: DRV_W] ==
                DRV_W'((32'd1 << pin_drv_lvl[p*LVL_W +: LVL_W]) - 32'd1))
            else $error("a_r8_thermo_lvl");
    end

endmodule

bind pcfg_bank pcfg_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_mask     (wdata[31:16]),
    .rdata       (rdata),
    .rvalid      (rvalid),
    .pin_func    (pin_func),
    .pin_drive   (pin_drive),
    .pin_drv_lvl (pin_drv_lvl),
    .pin_drv_err (pin_drv_err),
    .pin_pull    (pin_pull),
    .pin_smt     (pin_smt)
);

// File: tb/tb_pcfg_bank.sv
module tb_pcfg_bank;

    localparam int CLK_P = 10;
    localparam int NVEC  = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [5:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         rvalid;
    logic [127:0] pin_func;
    logic [255:0] pin_drive;
    logic [127:0] pin_drv_lvl;
    logic [31:0]  pin_drv_err;
    logic [63:0]  pin_pull;
    logic [31:0]  pin_smt;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    pcfg_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .rvalid      (rvalid),
        .pin_func    (pin_func),
        .pin_drive   (pin_drive),
        .pin_drv_lvl (pin_drv_lvl),
        .pin_drv_err (pin_drv_err),
        .pin_pull    (pin_pull),
        .pin_smt     (pin_smt)
    );

    // {address, write word, expected read-back of bits 15:0}
    localparam logic [53:0] VEC [NVEC] = '{
        {6'h00, 32'hFFFF_A5C3, 16'hA5C3},  // R1 full mask, R4
        {6'h00, 32'h00F0_1234, 16'hA533},  // R1 one nibble enabled
        {6'h10, 32'hFFFF_FF07, 16'hFF07},  // R5 pins 0,1
        {6'h27, 32'hFFFF_ABCD, 16'h00CD},  // R7 upper byte not stored
        {6'h25, 32'hFFFF_9C01, 16'h9C01},  // R6 pins 24..31
        {6'h23, 32'h0F00_FFFF, 16'h0F00},  // R4 high region, R1 partial
        {6'h08, 32'hFFFF_FFFF, 16'h0000},  // R9 unmapped gap
        {6'h1F, 32'h00FF_0003, 16'h0003},  // R5 last drive word
        {6'h04, 32'h0000_FFFF, 16'h0000},  // R1 zero mask
        {6'h3F, 32'hFFFF_FFFF, 16'h0000},  // R9 top of space
        {6'h11, 32'hFFFF_0501, 16'h0501},  // R8 pin 3 gapped pattern
        {6'h02, 32'hFF00_7700, 16'h7700}   // R4 pins 8..11
    };

    task automatic check(input string req, input logic [639:0] act, input logic [639:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        v = rvalid;
    endtask

    function automatic logic [639:0] all_outs();
        return {pin_func, pin_drive, pin_drv_lvl, pin_drv_err, pin_pull, pin_smt};
    endfunction

    initial begin
        #(CLK_P * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0]  rd;
        logic         v;
        logic [639:0] snap;

        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 outputs at reset", all_outs(), '0);
        check("R2 read port at reset", {rvalid, rdata}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: write then read back
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][53:48], VEC[i][47:16]);
            do_read(VEC[i][53:48], rd, v);
            check($sformatf("R1 R3 R9 table entry %0d data", i), rd, {16'h0, VEC[i][15:0]});
            check($sformatf("R3 table entry %0d valid", i), v, 1'b1);
        end

        // R4 function fields on the pins
        check("R4 pins 0-3 func", pin_func[15:0], 16'hA533);
        check("R4 pin 11 func", pin_func[11*4 +: 4], 4'h7);
        check("R4 pin 30 func high region", pin_func[30*4 +: 4], 4'hF);
        // R5 drive fields
        check("R5 pins 0,1 drive", pin_drive[15:0], 16'hFF07);
        check("R5 pin 30 drive", pin_drive[30*8 +: 8], 8'h03);
        // R8 level count and error flag
        check("R8 pin 0 level", pin_drv_lvl[0 +: 4], 4'd3);
        check("R8 pin 1 level", pin_drv_lvl[4 +: 4], 4'd8);
        check("R8 pin 30 level", pin_drv_lvl[30*4 +: 4], 4'd2);
        check("R8 pin 2 level", pin_drv_lvl[2*4 +: 4], 4'd1);
        check("R8 pin 3 level", pin_drv_lvl[3*4 +: 4], 4'd2);
        check("R8 error flags", pin_drv_err, 32'h0000_0008);
        // R6 pull
        check("R6 pins 24-31 pull", pin_pull[63:48], 16'h9C01);
        check("R1 zero-mask pull unchanged", pin_pull[15:0], 16'h0000);
        // R7 Schmitt
        check("R7 smt pins", pin_smt, 32'hCD00_0000);

        // R9 unmapped write and read
        snap = all_outs();
        do_write(6'h30, 32'hFFFF_FFFF);
        check("R9 unmapped write no effect", all_outs(), snap);
        do_read(6'h0A, rd, v);
        check("R9 unmapped read", {v, rd}, {1'b1, 32'h0});

        // R3 read together with write returns the old value
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 6'h05; wdata = 32'hFFFF_1111;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        check("R3 same-cycle read old value", {rvalid, rdata}, {1'b1, 32'h0});
        check("R6 pins 8-15 pull", pin_pull[31:16], 16'h1111);
        do_read(6'h05, rd, v);
        check("R3 read after write", rd, 32'h0000_1111);
        @(negedge clk);
        check("R3 idle read port", {rvalid, rdata}, '0);

        // R10 write visible only after the edge
        @(negedge clk);
        wr_en = 1'b1; addr = 6'h12; wdata = 32'hFFFF_0F3F;
        #1;
        check("R10 before edge", pin_drive[4*8 +: 16], 16'h0000);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        check("R10 after edge", pin_drive[4*8 +: 16], 16'h0F3F);

        // R7 low region, upper byte dropped
        do_write(6'h06, 32'hFFFF_FF81);
        do_read(6'h06, rd, v);
        check("R7 smt read upper zero", rd, 32'h0000_0081);
        check("R7 smt pins 0-7", pin_smt[7:0], 8'h81);

        // R2 reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 outputs after mid reset", all_outs(), '0);
        rst_n = 1'b1;
        do_read(6'h00, rd, v);
        check("R2 stored word cleared", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule